// File: doc/BRIEF.md
# Cell Slot Transmit Schedule Sequencer

This block walks a transmit schedule kept in local memory and, once per outgoing cell slot, decides what the slot carries. Each schedule word holds a two-bit operation code in bits 30:29 and a local memory address in its low bits. The operation is one of four: an idle cell, a cell from a constant-rate channel, a slot handed to the variable-rate service, or a jump. A constant-rate slot passes on the address of that channel's segmentation descriptor. A jump entry produces no cell. It reloads the read pointer, and the sequencer goes on reading from the new location.

Software normally keeps two schedules side by side in memory, each closed by a jump entry. It moves transmission from one schedule to the other by writing the base register. The write is held until the next jump entry, so a pass through a schedule is never cut in the middle. Memory reads have one cycle of latency. The next entry is fetched while the current slot is being issued. The slot decision is registered and is given together with the descriptor address.

Top module: `cell_sched_seq`

## Requirements
- R1: After reset, no slot decision is valid, the error flag is low, the base register reads the reset base (0), and the first memory read is at the reset base.
- R2: An entry with code 00 yields an idle decision: kind 00 and descriptor 0.
- R3: An entry with code 01 yields kind 01, and the descriptor equals the entry's low ADDR_W bits. Every other kind carries descriptor 0.
- R4: An entry with code 10 yields kind 10 when variable-rate work is pending at the tick. Otherwise it yields an idle decision.
- R5: An entry with code 11 uses no slot. The next entry is read from its address field, and up to two jumps in a row are followed without error.
- R6: Each slot tick gives exactly one decision pulse, one cycle after the tick. There is no pulse without a tick.
- R7: A base register write can be read back on the next cycle. The write redirects the read pointer only at the next jump entry, in place of that jump's target.
- R8: A third jump entry in a row sets a sticky table error. From then on, every slot is idle.
- R9: A tick that arrives while no entry is ready yields an idle decision and does not consume the pending entry.
- R10: Reads are never issued on two consecutive cycles. The fetch of the next entry starts in the cycle right after a slot consumes an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | ADDR_W | New schedule base address |
| base_rdata | output | ADDR_W | Current base register value |
| slot_tick | input | 1 | One-cycle pulse per outgoing cell slot |
| vr_pending | input | 1 | Variable-rate cell is waiting |
| mem_rd_en | output | 1 | Schedule memory read request |
| mem_raddr | output | ADDR_W | Schedule memory read address |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| slot_valid | output | 1 | Slot decision valid |
| slot_kind | output | 2 | 00 idle, 01 constant-rate, 10 variable-rate |
| slot_desc | output | ADDR_W | Descriptor address for constant-rate slots |
| tbl_err | output | 1 | Sticky jump-chain error |

## Verification
The properties assume that read data arrives exactly one cycle after each request. They also assume that slot ticks are single-cycle pulses and that vr_pending is steady around each tick. The bench memory model returns registered data one cycle after every read. Ticks are spaced ten cycles apart, which leaves time for up to two jumps between slots. The only exception is one deliberate back-to-back tick, placed to land while the next entry is still being decoded.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_FIXED = 2'b01,
    OP_VAR   = 2'b10,
    OP_JUMP  = 2'b11
  } op_e;

  localparam int OP_LSB = 29;
  localparam int WORD_W = 32;
endpackage

// File: rtl/tss_fetch.sv
module tss_fetch
  import tss_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int RESET_BASE = 0,
  parameter int MAX_JUMPS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              consume,
  output logic              ready,
  output op_e               ent_op,
  output logic [ADDR_W-1:0] ent_addr,
  output logic              err
);
  localparam int JW = $clog2(MAX_JUMPS + 1);

  typedef enum logic [1:0] {F_REQ, F_DEC, F_HOLD, F_ERR} fst_e;

  fst_e              state;
  logic [ADDR_W-1:0] ptr;
  logic              pend;
  logic [JW-1:0]     jcnt;
  op_e               dec_op;
  logic [ADDR_W-1:0] dec_addr;
  logic              is_jump, chain_full, jump_take;
  logic              unused_rdata;

  assign dec_op       = op_e'(mem_rdata[OP_LSB+1:OP_LSB]);
  assign dec_addr     = mem_rdata[ADDR_W-1:0];
  assign unused_rdata = ^{mem_rdata[WORD_W-1], mem_rdata[OP_LSB-1:ADDR_W]};
  assign is_jump      = (state == F_DEC) && (dec_op == OP_JUMP);
  assign chain_full   = (jcnt == JW'(MAX_JUMPS));
  assign jump_take    = is_jump && !chain_full;

  assign mem_rd_en = (state == F_REQ);
  assign mem_raddr = ptr;
  assign ready     = (state == F_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= F_REQ;
      ptr      <= ADDR_W'(RESET_BASE);
      base_q   <= ADDR_W'(RESET_BASE);
      pend     <= 1'b0;
      jcnt     <= '0;
      err      <= 1'b0;
      ent_op   <= OP_IDLE;
      ent_addr <= '0;
    end else begin
      if (base_wr) base_q <= base_wdata;
      pend <= base_wr | (pend & ~jump_take);
      case (state)
        F_REQ: state <= F_DEC;
        F_DEC: begin
          if (dec_op == OP_JUMP) begin
            if (chain_full) begin
              state <= F_ERR;
              err   <= 1'b1;
            end else begin
              jcnt  <= jcnt + 1'b1;
              ptr   <= pend ? base_q : dec_addr;
              state <= F_REQ;
            end
          end else begin
            ent_op   <= dec_op;
            ent_addr <= dec_addr;
            ptr      <= ptr + 1'b1;
            jcnt     <= '0;
            state    <= F_HOLD;
          end
        end
        F_HOLD: if (consume) state <= F_REQ;
        default: state <= F_ERR;
      endcase
    end
  end
endmodule

// File: rtl/tss_issue.sv
module tss_issue
  import tss_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              vr_pending,
  input  logic              ready,
  input  logic              err,
  input  op_e               ent_op,
  input  logic [ADDR_W-1:0] ent_addr,
  output logic              consume,
  output logic              slot_valid,
  output logic [1:0]        slot_kind,
  output logic [ADDR_W-1:0] slot_desc
);
  op_e               nxt_kind;
  logic [ADDR_W-1:0] nxt_desc;

  assign consume = tick & ready & ~err;

  always_comb begin
    nxt_kind = OP_IDLE;
    nxt_desc = '0;
    if (consume) begin
      case (ent_op)
        OP_FIXED: begin
          nxt_kind = OP_FIXED;
          nxt_desc = ent_addr;
        end
        OP_VAR:  nxt_kind = vr_pending ? OP_VAR : OP_IDLE;
        default: nxt_kind = OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
      slot_kind  <= 2'b00;
      slot_desc  <= '0;
    end else begin
      slot_valid <= tick;
      slot_kind  <= tick ? nxt_kind : OP_IDLE;
      slot_desc  <= tick ? nxt_desc : '0;
    end
  end
endmodule

// File: rtl/cell_sched_seq.sv
module cell_sched_seq
  import tss_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int RESET_BASE = 0,
  parameter int MAX_JUMPS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_rdata,
  input  logic              slot_tick,
  input  logic              vr_pending,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [31:0]       mem_rdata,
  output logic              slot_valid,
  output logic [1:0]        slot_kind,
  output logic [ADDR_W-1:0] slot_desc,
  output logic              tbl_err
);
  logic              consume, ready;
  op_e               ent_op;
  logic [ADDR_W-1:0] ent_addr;

  tss_fetch #(.ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE), .MAX_JUMPS(MAX_JUMPS)) u_fetch (
    .clk(clk), .rst(rst), .base_wr(base_wr), .base_wdata(base_wdata), .base_q(base_rdata),
    .mem_rd_en(mem_rd_en), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .consume(consume), .ready(ready), .ent_op(ent_op), .ent_addr(ent_addr), .err(tbl_err)
  );

  tss_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst(rst), .tick(slot_tick), .vr_pending(vr_pending), .ready(ready),
    .err(tbl_err), .ent_op(ent_op), .ent_addr(ent_addr), .consume(consume),
    .slot_valid(slot_valid), .slot_kind(slot_kind), .slot_desc(slot_desc)
  );
endmodule

// File: rtl/cell_sched_seq_chk.sv
module cell_sched_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              base_wr,
  input logic [ADDR_W-1:0] base_wdata,
  input logic [ADDR_W-1:0] base_rdata,
  input logic              slot_tick,
  input logic              vr_pending,
  input logic              mem_rd_en,
  input logic              slot_valid,
  input logic [1:0]        slot_kind,
  input logic [ADDR_W-1:0] slot_desc,
  input logic              tbl_err
);
  a_r6_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
    slot_tick |=> slot_valid);
  a_r6_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> !slot_valid);
  a_r2_kind_legal: assert property (@(posedge clk) disable iff (rst)
    slot_valid |-> slot_kind != 2'b11);
  a_r3_desc_only_fixed: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && slot_kind != 2'b01) |-> slot_desc == '0);
  a_r4_var_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && slot_kind == 2'b10) |-> $past(vr_pending));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    tbl_err |=> tbl_err);
  a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && tbl_err) |-> slot_kind == 2'b00);
  a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  a_r7_base_readback: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> base_rdata == $past(base_wdata));
endmodule

bind cell_sched_seq cell_sched_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .base_wr(base_wr), .base_wdata(base_wdata),
  .base_rdata(base_rdata), .slot_tick(slot_tick), .vr_pending(vr_pending),
  .mem_rd_en(mem_rd_en), .slot_valid(slot_valid), .slot_kind(slot_kind),
  .slot_desc(slot_desc), .tbl_err(tbl_err)
);

// File: tb/tb_cell_sched_seq.sv
module tb_cell_sched_seq;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          base_wr = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic [AW-1:0] base_rdata;
  logic          slot_tick = 1'b0;
  logic          vr_pending = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_raddr;
  logic [31:0]   mem_rdata;
  logic          slot_valid;
  logic [1:0]    slot_kind;
  logic [AW-1:0] slot_desc;
  logic          tbl_err;

  int  checks = 0;
  int  errs   = 0;
  bit  done   = 0;
  logic [1:0]    q_kind[$];
  logic [AW-1:0] q_desc[$];
  string         q_req[$];
  logic [31:0]   mem [256];
  logic          prev_rd = 1'b0;

  always #2 clk = ~clk;

  cell_sched_seq dut (
    .clk(clk), .rst(rst), .base_wr(base_wr), .base_wdata(base_wdata),
    .base_rdata(base_rdata), .slot_tick(slot_tick), .vr_pending(vr_pending),
    .mem_rd_en(mem_rd_en), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .slot_valid(slot_valid), .slot_kind(slot_kind), .slot_desc(slot_desc),
    .tbl_err(tbl_err)
  );

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_raddr[7:0]];

  function automatic logic [31:0] ent(input logic [1:0] op, input logic [AW-1:0] a);
    return {1'b0, op, 12'b0, a};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(!(prev_rd && mem_rd_en), "R10", "back-to-back read", 1, 0);
      prev_rd = mem_rd_en;
      if (slot_valid) begin
        if (q_kind.size() == 0) begin
          chk(0, "R6", "unexpected decision", 1, 0);
        end else begin
          automatic logic [1:0]    ek = q_kind.pop_front();
          automatic logic [AW-1:0] ed = q_desc.pop_front();
          automatic string         rq = q_req.pop_front();
          chk(slot_kind == ek, rq, "slot kind", slot_kind, ek);
          chk(slot_desc == ed, rq, "slot desc", slot_desc, ed);
        end
      end
    end
  end

  task automatic push_exp(input logic [1:0] k, input logic [AW-1:0] d, input string rq);
    q_kind.push_back(k);
    q_desc.push_back(d);
    q_req.push_back(rq);
  endtask

  task automatic do_tick(input logic vr, input logic [1:0] ek, input logic [AW-1:0] ed,
                         input string rq, input bit pref);
    @(negedge clk);
    slot_tick = 1'b1;
    vr_pending = vr;
    push_exp(ek, ed, rq);
    @(negedge clk);
    slot_tick = 1'b0;
    chk(slot_valid == 1'b1, "R6", "pulse one cycle after tick", slot_valid, 1);
    if (pref) chk(mem_rd_en == 1'b1, "R10", "prefetch after consume", mem_rd_en, 1);
    @(negedge clk);
    chk(slot_valid == 1'b0, "R6", "single-cycle pulse", slot_valid, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic wr_base(input logic [AW-1:0] a);
    @(negedge clk);
    base_wr = 1'b1;
    base_wdata = a;
    @(negedge clk);
    base_wr = 1'b0;
    chk(base_rdata == a, "R7", "base readback", base_rdata, a);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = ent(2'b00, '0);
    mem[8'h00] = ent(2'b01, 17'h01234);
    mem[8'h01] = ent(2'b00, 17'h00055);
    mem[8'h02] = ent(2'b10, '0);
    mem[8'h03] = ent(2'b10, '0);
    mem[8'h04] = ent(2'b01, 17'h000A0);
    mem[8'h05] = ent(2'b11, 17'h00000);
    mem[8'h40] = ent(2'b01, 17'h0BEEF);
    mem[8'h41] = ent(2'b11, 17'h00042);
    mem[8'h42] = ent(2'b11, 17'h00043);
    mem[8'h43] = ent(2'b01, 17'h00777);
    mem[8'h44] = ent(2'b11, 17'h00040);
    mem[8'h80] = ent(2'b11, 17'h00081);
    mem[8'h81] = ent(2'b11, 17'h00082);
    mem[8'h82] = ent(2'b11, 17'h00080);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(slot_valid == 1'b0, "R1", "valid after reset", slot_valid, 0);
    chk(tbl_err == 1'b0, "R1", "error after reset", tbl_err, 0);
    chk(base_rdata == '0, "R1", "base after reset", base_rdata, 0);
    chk(mem_rd_en == 1'b1 && mem_raddr == '0, "R1", "first read at base", mem_raddr, 0);
    repeat (6) @(negedge clk);

    do_tick(1'b0, 2'b01, 17'h01234, "R3", 1'b1);
    do_tick(1'b1, 2'b00, '0, "R2", 1'b1);
    // variable-rate slot followed by a tick that lands while the next entry decodes
    @(negedge clk);
    slot_tick = 1'b1; vr_pending = 1'b1;
    push_exp(2'b10, '0, "R4");
    @(negedge clk);
    slot_tick = 1'b0;
    @(negedge clk);
    slot_tick = 1'b1;
    push_exp(2'b00, '0, "R9");
    @(negedge clk);
    slot_tick = 1'b0;
    repeat (8) @(negedge clk);
    do_tick(1'b1, 2'b10, '0, "R9", 1'b1);
    do_tick(1'b0, 2'b01, 17'h000A0, "R3", 1'b1);
    do_tick(1'b0, 2'b01, 17'h01234, "R5", 1'b1);
    wr_base(17'h00040);
    do_tick(1'b0, 2'b00, '0, "R7", 1'b1);
    do_tick(1'b0, 2'b00, '0, "R4", 1'b1);
    do_tick(1'b1, 2'b10, '0, "R4", 1'b1);
    do_tick(1'b0, 2'b01, 17'h000A0, "R7", 1'b1);
    do_tick(1'b0, 2'b01, 17'h0BEEF, "R7", 1'b1);
    do_tick(1'b0, 2'b01, 17'h00777, "R5", 1'b1);
    chk(tbl_err == 1'b0, "R8", "two jumps in a row tolerated", tbl_err, 0);
    do_tick(1'b0, 2'b01, 17'h0BEEF, "R5", 1'b1);
    wr_base(17'h00080);
    do_tick(1'b0, 2'b01, 17'h00777, "R7", 1'b1);
    chk(tbl_err == 1'b1, "R8", "third jump sets error", tbl_err, 1);
    do_tick(1'b1, 2'b00, '0, "R8", 1'b0);
    do_tick(1'b0, 2'b00, '0, "R8", 1'b0);
    chk(tbl_err == 1'b1, "R8", "error sticky", tbl_err, 1);
    chk(q_kind.size() == 0, "R6", "all decisions seen", q_kind.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule